// File: doc/BRIEF.md
# Audio Elastic Sample Buffer

This block sits between a host-paced link and a local audio converter. Stereo frames arrive on the write side whenever the link has them, often as bursts. The read side is clocked by the converter's own sample clock, which is the timing master, and it takes out one frame per sample tick. The two sides run on unrelated clocks. Their pointers cross between the domains as Gray code through two-flop synchronizers.

Read-out does not begin until the buffer holds half its depth. The read pointer therefore trails the write pointer by about half the buffer, and that gap soaks up arrival jitter. A refill request on the write side goes high when the fill level drops under a low watermark, so the producer can send another burst of frames.

Two faults are recorded with sticky flags. A write into a full buffer is dropped and flags an overrun. A tick that finds the buffer empty while playing outputs silence, flags an underrun, and re-arms the half-full start. The read controller has two states. PRIME outputs silence and moves to PLAY (transition ARM) once the read-side fill reaches half depth. PLAY outputs stored frames and goes back to PRIME (transition STARVE) when a tick meets an empty buffer.

Top module: `aeb_elastic_buf`

## Requirements
- R1: After reset, rd_left and rd_right are 0, rd_valid, rd_running, wr_overrun and rd_underrun are 0, and wr_refill is 1.
- R2: While in PRIME, every tick produces rd_left = rd_right = 0 with rd_valid = 0, and PLAY is not entered until the read-side fill reaches DEPTH/2 (32 frames by default).
- R3: In PLAY, each tick registers the oldest stored frame onto rd_left/rd_right, with rd_valid = 1, at the rd_clk edge that samples the tick. Frames leave in write order.
- R4: wr_refill is 1 exactly when the write-side fill (written minus read, as seen through the synchronizer) is below LOW_MARK (16 by default).
- R5: A tick in PLAY with an empty buffer outputs zero with rd_valid = 0, sets rd_underrun, and returns to PRIME. rd_underrun stays set until reset.
- R6: After an underrun, play resumes only once DEPTH/2 frames are held again.
- R7: A write while the buffer holds DEPTH frames is dropped, leaves the stored frames unchanged, and sets wr_overrun, which stays set until reset.
- R8: The pointer copies sent across domains change by at most one bit per clock of their own domain.
- R9: rd_running is 1 exactly while the read controller is in PLAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Link-side clock |
| wr_rst_n | input | 1 | Link-side asynchronous reset, active low |
| wr_en | input | 1 | Store one frame this cycle |
| wr_left | input | SW | Left sample to store |
| wr_right | input | SW | Right sample to store |
| wr_refill | output | 1 | Fill is below the low watermark |
| wr_overrun | output | 1 | Sticky: a write was dropped because the buffer was full |
| rd_clk | input | 1 | Converter sample-side clock |
| rd_rst_n | input | 1 | Sample-side asynchronous reset, active low |
| rd_tick | input | 1 | One frame is due this cycle |
| rd_left | output | SW | Left sample out (0 when silent) |
| rd_right | output | SW | Right sample out (0 when silent) |
| rd_valid | output | 1 | The current output frame came from the buffer |
| rd_running | output | 1 | Controller is in PLAY |
| rd_underrun | output | 1 | Sticky: a tick found the buffer empty while playing |

## Verification
The checker watches, on every cycle, that the crossing pointers change one bit at a time, that the fill never goes past the depth, that a full-buffer write leaves the write pointer alone, that silent frames are all zero, that valid frames only appear while playing, and that both fault flags stay set. The bench scenarios are needed to show frame order, the exact half-full start and its re-arm after a starve, the exact watermark crossing, and that dropped frames never reach the output. All of these depend on sequences of writes and ticks across both clocks.

// File: rtl/aeb_pkg.sv
package aeb_pkg;
    typedef enum logic [0:0] {
        RD_PRIME = 1'b0,
        RD_PLAY  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/aeb_ptr_xfer.sv
// Two-flop capture of a Gray pointer from the other domain, decoded to binary.
module aeb_ptr_xfer #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = PW - 1; i >= 0; i--) begin
            acc        = acc ^ sync_q[i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/aeb_store.sv
// Frame storage: written on the link clock, read combinationally by address.
module aeb_store #(
    parameter int AW = 6,
    parameter int DW = 48
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/aeb_wr_ctrl.sv
// Link-side pointer, full detection, refill request and overrun flag.
module aeb_wr_ctrl #(
    parameter int AW       = 6,
    parameter int LOW_MARK = 16
) (
    input  logic        wr_clk,
    input  logic        wr_rst_n,
    input  logic        wr_en,
    input  logic [AW:0] rbin_sync,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic [AW:0] fill,
    output logic        full,
    output logic        we,
    output logic        refill,
    output logic        overrun
);
    localparam int PW = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] LOW_P   = PW'(LOW_MARK);

    logic [PW-1:0] wbin_nx;

    assign fill    = wbin - rbin_sync;
    assign full    = (fill == DEPTH_P);
    assign we      = wr_en & ~full;
    assign refill  = (fill < LOW_P);
    assign wbin_nx = wbin + 1'b1;

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            overrun <= 1'b0;
        end else begin
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (wr_en && full) begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aeb_rd_ctrl.sv
// Sample-side controller: PRIME until half full, PLAY one frame per tick.
module aeb_rd_ctrl
    import aeb_pkg::*;
#(
    parameter int AW = 6,
    parameter int SW = 24
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          tick,
    input  logic [AW:0]   wbin_sync,
    input  logic [2*SW-1:0] rdata,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [SW-1:0] left,
    output logic [SW-1:0] right,
    output logic          valid,
    output logic          underrun,
    output logic          running
);
    localparam int PW = AW + 1;
    localparam int HALF = (1 << AW) / 2;
    localparam logic [PW-1:0] HALF_P = PW'(HALF);

    rd_state_e     state_q;
    rd_state_e     state_nx;
    logic [PW-1:0] fill;
    logic [PW-1:0] rbin_nx;
    logic          empty;

    assign fill    = wbin_sync - rbin;
    assign empty   = (fill == '0);
    assign rbin_nx = rbin + 1'b1;
    assign running = (state_q == RD_PLAY);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RD_PRIME: if (fill >= HALF_P) state_nx = RD_PLAY;   // ARM
            RD_PLAY:  if (tick && empty)  state_nx = RD_PRIME;  // STARVE
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) state_q <= RD_PRIME;
        else           state_q <= state_nx;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            left     <= '0;
            right    <= '0;
            valid    <= 1'b0;
            underrun <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                RD_PRIME: begin
                    left  <= '0;
                    right <= '0;
                    valid <= 1'b0;
                end
                RD_PLAY: begin
                    if (empty) begin
                        left     <= '0;
                        right    <= '0;
                        valid    <= 1'b0;
                        underrun <= 1'b1;
                    end else begin
                        left  <= rdata[2*SW-1:SW];
                        right <= rdata[SW-1:0];
                        valid <= 1'b1;
                        rbin  <= rbin_nx;
                        rgray <= rbin_nx ^ (rbin_nx >> 1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/aeb_elastic_buf.sv
module aeb_elastic_buf #(
    parameter int SW       = 24,
    parameter int AW       = 6,
    parameter int LOW_MARK = 16
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_left,
    input  logic [SW-1:0] wr_right,
    output logic          wr_refill,
    output logic          wr_overrun,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_tick,
    output logic [SW-1:0] rd_left,
    output logic [SW-1:0] rd_right,
    output logic          rd_valid,
    output logic          rd_running,
    output logic          rd_underrun
);
    localparam int PW = AW + 1;
    localparam int DW = 2 * SW;

    logic [PW-1:0] w_bin, w_gray, w_fill, r_bin_at_w;
    logic [PW-1:0] r_bin, r_gray, w_bin_at_r;
    logic          w_full, w_we;
    logic [DW-1:0] r_data;

    aeb_wr_ctrl #(.AW(AW), .LOW_MARK(LOW_MARK)) u_wr (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .wr_en     (wr_en),
        .rbin_sync (r_bin_at_w),
        .wbin      (w_bin),
        .wgray     (w_gray),
        .fill      (w_fill),
        .full      (w_full),
        .we        (w_we),
        .refill    (wr_refill),
        .overrun   (wr_overrun)
    );

    aeb_ptr_xfer #(.PW(PW)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (r_gray),
        .bin_out (r_bin_at_w)
    );

    aeb_ptr_xfer #(.PW(PW)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (w_gray),
        .bin_out (w_bin_at_r)
    );

    aeb_store #(.AW(AW), .DW(DW)) u_store (
        .wr_clk (wr_clk),
        .we     (w_we),
        .waddr  (w_bin[AW-1:0]),
        .wdata  ({wr_left, wr_right}),
        .raddr  (r_bin[AW-1:0]),
        .rdata  (r_data)
    );

    aeb_rd_ctrl #(.AW(AW), .SW(SW)) u_rd (
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .tick      (rd_tick),
        .wbin_sync (w_bin_at_r),
        .rdata     (r_data),
        .rbin      (r_bin),
        .rgray     (r_gray),
        .left      (rd_left),
        .right     (rd_right),
        .valid     (rd_valid),
        .underrun  (rd_underrun),
        .running   (rd_running)
    );
endmodule

// File: rtl/aeb_elastic_buf_chk.sv
module aeb_elastic_buf_chk #(
    parameter int SW = 24,
    parameter int AW = 6
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_en,
    input logic          w_full,
    input logic [AW:0]   w_fill,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   w_gray,
    input logic [AW:0]   r_gray,
    input logic          wr_overrun,
    input logic          rd_valid,
    input logic          rd_running,
    input logic          rd_underrun,
    input logic [SW-1:0] rd_left,
    input logic [SW-1:0] rd_right
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    p_gray_wr_r8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    p_gray_rd_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);

    p_fill_bound_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        w_fill <= DEPTH_P);

    p_drop_when_full_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && w_full) |=> $stable(w_bin));

    p_overrun_sticky_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overrun |=> wr_overrun);

    p_underrun_sticky_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_underrun |=> rd_underrun);

    p_silent_zero_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_valid |-> (rd_left == '0 && rd_right == '0));

    p_valid_playing_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> rd_running);
endmodule

bind aeb_elastic_buf aeb_elastic_buf_chk #(.SW(SW), .AW(AW)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .wr_en       (wr_en),
    .w_full      (w_full),
    .w_fill      (w_fill),
    .w_bin       (w_bin),
    .w_gray      (w_gray),
    .r_gray      (r_gray),
    .wr_overrun  (wr_overrun),
    .rd_valid    (rd_valid),
    .rd_running  (rd_running),
    .rd_underrun (rd_underrun),
    .rd_left     (rd_left),
    .rd_right    (rd_right)
);

// File: tb/aeb_elastic_buf_tb.sv
`timescale 1ns/1ps
module aeb_elastic_buf_tb;
    localparam int SW = 24;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HALF = DEPTH / 2;
    localparam int LOW = 16;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic wr_en = 1'b0, rd_tick = 1'b0;
    logic [SW-1:0] wr_left = '0, wr_right = '0;
    logic wr_refill, wr_overrun, rd_valid, rd_running, rd_underrun;
    logic [SW-1:0] rd_left, rd_right;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [2*SW-1:0] q[$];

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    aeb_elastic_buf #(.SW(SW), .AW(AW), .LOW_MARK(LOW)) u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en),
        .wr_left(wr_left), .wr_right(wr_right),
        .wr_refill(wr_refill), .wr_overrun(wr_overrun),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_tick(rd_tick),
        .rd_left(rd_left), .rd_right(rd_right), .rd_valid(rd_valid),
        .rd_running(rd_running), .rd_underrun(rd_underrun)
    );

    function automatic logic [2*SW-1:0] pattern(int n);
        return {SW'(24'hA00000 + n), SW'(24'h500000 - n * 3)};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic [2*SW-1:0] f, bit keep);
        @(negedge wr_clk);
        wr_en = 1'b1;
        {wr_left, wr_right} = f;
        if (keep) q.push_back(f);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge rd_clk);
        repeat (10) @(negedge wr_clk);
    endtask

    // one tick; expect a stored frame when play_exp, silence otherwise
    task automatic tick_chk(bit play_exp, string req);
        logic [2*SW-1:0] exp;
        @(negedge rd_clk);
        rd_tick = 1'b1;
        @(negedge rd_clk);
        rd_tick = 1'b0;
        exp = '0;
        if (play_exp) exp = q.pop_front();
        check(rd_valid == play_exp, req, 64'(rd_valid), 64'(play_exp));
        check({rd_left, rd_right} == exp, req, 64'({rd_left, rd_right}), 64'(exp));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge wr_clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h1F2E);
        repeat (5) @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        @(negedge wr_clk);

        // R1 reset state
        check(rd_valid == 0 && rd_running == 0, "R1", 64'({rd_valid, rd_running}), 0);
        check({rd_left, rd_right} == 0, "R1", 64'({rd_left, rd_right}), 0);
        check(wr_overrun == 0 && rd_underrun == 0, "R1", 64'({wr_overrun, rd_underrun}), 0);
        check(wr_refill == 1, "R1", 64'(wr_refill), 1);

        // R2 priming: one short of half stays silent
        for (int i = 0; i < HALF - 1; i++) put(pattern(i), 1'b1);
        settle();
        for (int i = 0; i < 3; i++) tick_chk(1'b0, "R2");
        check(rd_running == 0, "R9", 64'(rd_running), 0);
        put(pattern(HALF - 1), 1'b1);
        settle();
        check(rd_running == 1, "R2", 64'(rd_running), 1);

        // R3 in-order play, R4 exact watermark edge
        for (int i = 0; i < HALF - LOW; i++) tick_chk(1'b1, "R3");
        settle();
        check(wr_refill == 0, "R4", 64'(wr_refill), 0);
        tick_chk(1'b1, "R3");
        settle();
        check(wr_refill == 1, "R4", 64'(wr_refill), 1);

        // R3/R4 random bursts against ticks
        for (int it = 0; it < 300; it++) begin
            @(negedge wr_clk);
            if (wr_refill) begin
                for (int k = 0; k < 16; k++) put({SW'($urandom), SW'($urandom)}, 1'b1);
            end
            repeat ($urandom_range(1, 4)) @(negedge rd_clk);
            tick_chk(1'b1, "R3");
        end
        check(wr_overrun == 0 && rd_underrun == 0, "R4", 64'({wr_overrun, rd_underrun}), 0);

        // R5 starve after draining
        settle();
        while (q.size() > 0) tick_chk(1'b1, "R3");
        settle();
        tick_chk(1'b0, "R5");
        check(rd_underrun == 1, "R5", 64'(rd_underrun), 1);
        check(rd_running == 0, "R5", 64'(rd_running), 0);

        // R6 re-arm needs half depth again
        for (int i = 0; i < HALF - 1; i++) put(pattern(100 + i), 1'b1);
        settle();
        tick_chk(1'b0, "R6");
        check(rd_running == 0, "R6", 64'(rd_running), 0);
        put(pattern(100 + HALF - 1), 1'b1);
        settle();
        check(rd_running == 1, "R6", 64'(rd_running), 1);
        while (q.size() > 0) tick_chk(1'b1, "R6");
        settle();
        tick_chk(1'b0, "R5");
        check(rd_underrun == 1, "R5", 64'(rd_underrun), 1);

        // R7 overrun: fill completely, extra writes dropped
        for (int i = 0; i < DEPTH; i++) put(pattern(300 + i), 1'b1);
        settle();
        check(wr_overrun == 0, "R7", 64'(wr_overrun), 0);
        for (int i = 0; i < 3; i++) put(pattern(900 + i), 1'b0);
        @(negedge wr_clk);
        check(wr_overrun == 1, "R7", 64'(wr_overrun), 1);
        check(wr_refill == 0, "R4", 64'(wr_refill), 0);
        while (q.size() > 0) tick_chk(1'b1, "R7");
        settle();
        tick_chk(1'b0, "R7");
        check(wr_overrun == 1 && rd_underrun == 1, "R7", 64'({wr_overrun, rd_underrun}), 3);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule